// File: doc/BRIEF.md
# Glitch-Free Clock Stop Controller

This block sits between the raw clock sources of a clock generator and its output buffers. It decides, output by output, when a clock runs and when it is held low. The inputs are four raw sources: a CPU clock, a PCI clock, an SDRAM clock and a reference clock. The block also takes per-output enable bits from a control register, a mode strap, two dual-purpose pins and an active-low power-down input. Every input is sampled on the rising edge of a fast system clock `clk_i`. The raw sources arrive as level signals that are synchronous to `clk_i`, and every clock output is a flop in the `clk_i` domain.

An output never starts or stops in the middle of a high phase. Whenever an output's request differs from its current state, a fixed handshake runs first. It waits for a rising edge of the PCI clock and then for a falling edge of that output's own source clock. Only then is the new state committed.

The mode strap chooses what the two dual-purpose pins do. In one setting they are active-low stop inputs: one stops the CPU clocks and the other stops the PCI clocks except the free-running one. In the other setting they carry two extra SDRAM clocks. Power-down clears every output at once. After power-down is released, each output comes back only through the same handshake.

Top module: `clkstop_ctrl`

## Requirements
- R1: While `rst_ni` is low, and directly after reset, every clock output and every `run_o` bit is 0. Each output starts stopped. A stopped output stays low.
- R2: A "sample" is the value at a rising edge of `clk_i`. An edge of a source is a sample that differs from the previous sample. Once an output's request differs from its run state, the state flips at the first sample that shows a falling edge of the output's own source. That falling edge must come strictly after a sample showing a rising edge of `pci_src_i`. The rising edge may fall on the same sample where the difference is first seen.
- R3: Outside power-down, every high pulse of an output lasts exactly as many samples as the high phase of its source.
- R4: An output's request is its enable bit ANDed with the permission of its stop pin. The CPU outputs depend on the CPU stop, PCI outputs 0..N-1 depend on the PCI stop, and every other output depends on its enable bit only.
- R5: With `mode_i` low, the pins are inputs (`dual_oe_o`=00): `dual_i[0]` is the active-low CPU stop and `dual_i[1]` is the active-low PCI stop. With `mode_i` high, `dual_oe_o`=11, `dual_o[0]`/`dual_o[1]` are SDRAM clocks 6 and 7 (enable bits `sdram_en_i[N_SDRAM]` and `sdram_en_i[N_SDRAM+1]`), and both stop functions are inactive. With `mode_i` low, the requests for these two clocks are 0.
- R6: An active CPU stop stops only the CPU outputs. The SDRAM outputs keep running.
- R7: An active PCI stop stops PCI outputs 0..N-1. The free-running PCI output is not affected.
- R8: While `pwr_dn_ni` is low, every clock output and every `run_o` bit is 0. This takes effect asynchronously, without waiting for a clock edge.
- R9: After `pwr_dn_ni` rises, each enabled output restarts only through the R2 handshake.
- R10: If a request returns to the run state before the state has flipped, the pending change is dropped and the output is unchanged.
- R11: At each sample an output's value becomes its source's sample ANDed with its run state before that sample. `run_o` shows the run states in this order from bit 0 up: CPU outputs, PCI outputs, the free-running PCI output, SDRAM 0..N-1, SDRAM 6/7 (the dual pins), then the reference outputs.
- R12: The stop pins pass through a SYNC_STAGES-flop synchronizer (default 2). A pin value sampled at edge k reaches the request logic at edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System sampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pwr_dn_ni | input | 1 | Active-low power-down |
| mode_i | input | 1 | 1: dual pins are clock outputs, 0: dual pins are stop inputs |
| cpu_src_i | input | 1 | Raw CPU clock |
| pci_src_i | input | 1 | Raw PCI clock (handshake anchor) |
| sdram_src_i | input | 1 | Raw SDRAM clock |
| ref_src_i | input | 1 | Raw reference clock |
| cpu_en_i | input | N_CPU | CPU output enables |
| pci_en_i | input | N_PCI | PCI output enables |
| pcif_en_i | input | 1 | Free-running PCI output enable |
| sdram_en_i | input | N_SDRAM+2 | SDRAM enables, top two for the dual pins |
| ref_en_i | input | N_REF | Reference output enables |
| dual_i | input | 2 | Dual pin input values (stop pins when mode low) |
| cpu_clk_o | output | N_CPU | Gated CPU clocks |
| pci_clk_o | output | N_PCI | Gated PCI clocks |
| pcif_clk_o | output | 1 | Free-running PCI clock |
| sdram_clk_o | output | N_SDRAM | Gated SDRAM clocks |
| ref_clk_o | output | N_REF | Gated reference clocks |
| dual_o | output | 2 | SDRAM clocks 6 and 7 on the dual pins |
| dual_oe_o | output | 2 | Output enables for the dual pins |
| run_o | output | N_CPU+N_PCI+N_SDRAM+N_REF+3 | Run state of every output |

## Verification
The bench drives the four sources at different periods and phases. CPU and SDRAM run in antiphase, PCI at half their rate, and the reference at a period of six samples. This shows whether each output waits for its own source's fall or for some other clock's fall. The bench applies several enable masks, then each stop pin alone, in both modes. This separates the stop that gates a group from the stop that must be ignored. A one-sample enable pulse placed where no PCI rise can occur shows whether a withdrawn request is dropped. A power-down pulse applied between edges shows whether outputs clear without a clock edge and whether they later restart through the handshake.

// File: rtl/clkstop_pkg.sv
`timescale 1ns/1ps
package clkstop_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RISE = 2'd1,
    PH_FALL = 2'd2
  } phase_e;

  localparam int SRC_CPU   = 0;
  localparam int SRC_PCI   = 1;
  localparam int SRC_SDRAM = 2;
  localparam int SRC_REF   = 3;
  localparam int N_SRC     = 4;
endpackage

// File: rtl/clkstop_sync.sv
`timescale 1ns/1ps
module clkstop_sync #(
  parameter int W = 2,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) chain_q[s] <= RST_VAL;
    end else begin
      chain_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/clkstop_edge.sv
`timescale 1ns/1ps
module clkstop_edge #(
  parameter int W = 4,
  parameter int ANCHOR = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sig_i,
  output logic [W-1:0] fall_o,
  output logic         anchor_rise_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= sig_i;
  end

  assign fall_o        = prev_q & ~sig_i;
  assign anchor_rise_o = sig_i[ANCHOR] & ~prev_q[ANCHOR];
endmodule

// File: rtl/clkstop_gate.sv
`timescale 1ns/1ps
module clkstop_gate
  import clkstop_pkg::*;
(
  input  logic clk_i,
  input  logic clr_ni,
  input  logic src_i,
  input  logic src_fall_i,
  input  logic anchor_rise_i,
  input  logic req_i,
  output logic gate_o,
  output logic clk_o
);
  phase_e phase_q, phase_d;
  logic   gate_q, gate_d, clk_q, differ;

  assign differ = req_i ^ gate_q;

  always_comb begin
    phase_d = phase_q;
    gate_d  = gate_q;
    unique case (phase_q)
      PH_IDLE: if (differ) phase_d = anchor_rise_i ? PH_FALL : PH_RISE;
      PH_RISE: begin
        if (!differ)            phase_d = PH_IDLE;
        else if (anchor_rise_i) phase_d = PH_FALL;
      end
      PH_FALL: begin
        if (!differ) phase_d = PH_IDLE;
        else if (src_fall_i) begin
          gate_d  = req_i;
          phase_d = PH_IDLE;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  // output flop shares the async clear so power-down drops it at once
  always_ff @(posedge clk_i or negedge clr_ni) begin
    if (!clr_ni) begin
      phase_q <= PH_IDLE;
      gate_q  <= 1'b0;
      clk_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      gate_q  <= gate_d;
      clk_q   <= src_i & gate_q;
    end
  end

  assign gate_o = gate_q;
  assign clk_o  = clk_q;

  AST_STOP_HOLDS_LOW: assert property (@(posedge clk_i) disable iff (!clr_ni)
    !gate_q |=> !clk_o); // R1
  AST_GATE_AT_FALL: assert property (@(posedge clk_i) disable iff (!clr_ni)
    !$stable(gate_q) |-> ($past(src_fall_i) && $past(phase_q) == PH_FALL)); // R2
  AST_RISE_WITH_SRC: assert property (@(posedge clk_i) disable iff (!clr_ni)
    $rose(clk_o) |-> $past(src_i)); // R3
  AST_FALL_WITH_SRC: assert property (@(posedge clk_i) disable iff (!clr_ni)
    $fell(clk_o) |-> !$past(src_i)); // R3
endmodule

// File: rtl/clkstop_ctrl.sv
`timescale 1ns/1ps
module clkstop_ctrl
  import clkstop_pkg::*;
#(
  parameter int N_CPU       = 4,
  parameter int N_PCI       = 6,
  parameter int N_SDRAM     = 6,
  parameter int N_REF       = 2,
  parameter int SYNC_STAGES = 2,
  localparam int N_TOT      = N_CPU + N_PCI + N_SDRAM + N_REF + 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pwr_dn_ni,
  input  logic               mode_i,
  input  logic               cpu_src_i,
  input  logic               pci_src_i,
  input  logic               sdram_src_i,
  input  logic               ref_src_i,
  input  logic [N_CPU-1:0]   cpu_en_i,
  input  logic [N_PCI-1:0]   pci_en_i,
  input  logic               pcif_en_i,
  input  logic [N_SDRAM+1:0] sdram_en_i,
  input  logic [N_REF-1:0]   ref_en_i,
  input  logic [1:0]         dual_i,
  output logic [N_CPU-1:0]   cpu_clk_o,
  output logic [N_PCI-1:0]   pci_clk_o,
  output logic               pcif_clk_o,
  output logic [N_SDRAM-1:0] sdram_clk_o,
  output logic [N_REF-1:0]   ref_clk_o,
  output logic [1:0]         dual_o,
  output logic [1:0]         dual_oe_o,
  output logic [N_TOT-1:0]   run_o
);
  localparam int O_PCI  = N_CPU;
  localparam int O_PCIF = O_PCI + N_PCI;
  localparam int O_SD   = O_PCIF + 1;
  localparam int O_DUAL = O_SD + N_SDRAM;
  localparam int O_REF  = O_DUAL + 2;

  logic              clr_n;
  logic [N_SRC-1:0]  src_v, fall_v;
  logic              anchor_rise;
  logic [1:0]        stop_n_sync;
  logic              cpu_allow, pci_allow;
  logic [N_TOT-1:0]  req_v, gate_v, clk_v;

  assign clr_n = rst_ni & pwr_dn_ni;

  always_comb begin
    src_v            = '0;
    src_v[SRC_CPU]   = cpu_src_i;
    src_v[SRC_PCI]   = pci_src_i;
    src_v[SRC_SDRAM] = sdram_src_i;
    src_v[SRC_REF]   = ref_src_i;
  end

  clkstop_edge #(.W(N_SRC), .ANCHOR(SRC_PCI)) u_edge (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .sig_i         (src_v),
    .fall_o        (fall_v),
    .anchor_rise_o (anchor_rise)
  );

  clkstop_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_stop_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (dual_i),
    .q_o    (stop_n_sync)
  );

  // in clock-output mode the stop functions are unavailable, i.e. inactive
  assign cpu_allow = mode_i | stop_n_sync[0];
  assign pci_allow = mode_i | stop_n_sync[1];

  always_comb begin
    for (int i = 0; i < N_CPU; i++)   req_v[i]          = cpu_en_i[i] & cpu_allow;
    for (int i = 0; i < N_PCI; i++)   req_v[O_PCI + i]  = pci_en_i[i] & pci_allow;
    req_v[O_PCIF] = pcif_en_i;
    for (int i = 0; i < N_SDRAM; i++) req_v[O_SD + i]   = sdram_en_i[i];
    for (int i = 0; i < 2; i++)       req_v[O_DUAL + i] = sdram_en_i[N_SDRAM + i] & mode_i;
    for (int i = 0; i < N_REF; i++)   req_v[O_REF + i]  = ref_en_i[i];
  end

  for (genvar g = 0; g < N_TOT; g++) begin : g_out
    localparam int SEL = (g < O_PCI) ? SRC_CPU :
                         (g < O_SD)  ? SRC_PCI :
                         (g < O_REF) ? SRC_SDRAM : SRC_REF;
    clkstop_gate u_gate (
      .clk_i         (clk_i),
      .clr_ni        (clr_n),
      .src_i         (src_v[SEL]),
      .src_fall_i    (fall_v[SEL]),
      .anchor_rise_i (anchor_rise),
      .req_i         (req_v[g]),
      .gate_o        (gate_v[g]),
      .clk_o         (clk_v[g])
    );
  end

  assign cpu_clk_o   = clk_v[O_PCI-1:0];
  assign pci_clk_o   = clk_v[O_PCIF-1:O_PCI];
  assign pcif_clk_o  = clk_v[O_PCIF];
  assign sdram_clk_o = clk_v[O_DUAL-1:O_SD];
  assign dual_o      = clk_v[O_REF-1:O_DUAL];
  assign ref_clk_o   = clk_v[N_TOT-1:O_REF];
  assign dual_oe_o   = {2{mode_i}};
  assign run_o       = gate_v;

  AST_PWR_FORCES_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_dn_ni |-> (clk_v == '0 && gate_v == '0)); // R8
endmodule

// File: tb/clkstop_ctrl_test.sv
`timescale 1ns/1ps
module clkstop_ctrl_test;
  localparam int PERIOD = 10;
  localparam int NT = 21;

  logic clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  logic rst_n, pwr_n, mode, cpu_s, pci_s, sd_s, ref_s, pcif_en;
  logic [3:0] cpu_en;
  logic [5:0] pci_en;
  logic [7:0] sd_en;
  logic [1:0] ref_en, dual_in;
  logic [3:0] cpu_o;
  logic [5:0] pci_o;
  logic pcif_o;
  logic [5:0] sd_o;
  logic [1:0] ref_o, dual_o, dual_oe;
  logic [NT-1:0] run;

  clkstop_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .pwr_dn_ni(pwr_n), .mode_i(mode),
    .cpu_src_i(cpu_s), .pci_src_i(pci_s), .sdram_src_i(sd_s), .ref_src_i(ref_s),
    .cpu_en_i(cpu_en), .pci_en_i(pci_en), .pcif_en_i(pcif_en), .sdram_en_i(sd_en),
    .ref_en_i(ref_en), .dual_i(dual_in),
    .cpu_clk_o(cpu_o), .pci_clk_o(pci_o), .pcif_clk_o(pcif_o), .sdram_clk_o(sd_o),
    .ref_clk_o(ref_o), .dual_o(dual_o), .dual_oe_o(dual_oe), .run_o(run)
  );

  int checks = 0, errors = 0, cyc = 0;
  string tag = "R1";

  // reference model state
  bit m_gate[NT], m_out[NT];
  int m_ph[NT], hl[NT];
  bit m_prev[4], m_s1[2], m_s2[2];

  function automatic int src_of(int j);
    if (j < 4) return 0;
    if (j < 11) return 1;
    if (j < 19) return 2;
    return 3;
  endfunction

  function automatic int high_width(int s);
    case (s)
      1: return 4;
      3: return 3;
      default: return 2;
    endcase
  endfunction

  task automatic check(input string t, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", t, act, exp);
    end
  endtask

  task automatic drive_src();
    cpu_s = cyc[1];
    pci_s = cyc[2];
    sd_s  = ~cyc[1];
    ref_s = (cyc % 6) < 3;
  endtask

  task automatic model_reset();
    for (int j = 0; j < NT; j++) begin
      m_gate[j] = 0; m_out[j] = 0; m_ph[j] = 0; hl[j] = 0;
    end
    for (int s = 0; s < 4; s++) m_prev[s] = 0;
    m_s1[0] = 1; m_s1[1] = 1; m_s2[0] = 1; m_s2[1] = 1;
  endtask

  task automatic model_clear();
    for (int j = 0; j < NT; j++) begin
      m_gate[j] = 0; m_out[j] = 0; m_ph[j] = 0; hl[j] = 0;
    end
  endtask

  task automatic model_step();
    bit sv[4], rise_pci, fall[4], req, cpu_ok, pci_ok, differ;
    sv[0] = cpu_s; sv[1] = pci_s; sv[2] = sd_s; sv[3] = ref_s;
    for (int s = 0; s < 4; s++) fall[s] = m_prev[s] && !sv[s];
    rise_pci = sv[1] && !m_prev[1];
    cpu_ok = mode || m_s2[0];
    pci_ok = mode || m_s2[1];
    for (int j = 0; j < NT; j++) begin
      if (j < 4)       req = cpu_en[j] && cpu_ok;
      else if (j < 10) req = pci_en[j-4] && pci_ok;
      else if (j == 10) req = pcif_en;
      else if (j < 17) req = sd_en[j-11];
      else if (j < 19) req = sd_en[j-11] && mode;
      else             req = ref_en[j-19];
      if (!pwr_n) begin
        m_out[j] = 0; m_gate[j] = 0; m_ph[j] = 0;
      end else begin
        m_out[j] = sv[src_of(j)] && m_gate[j];
        differ = (req != m_gate[j]);
        if (m_ph[j] == 0) begin
          if (differ) m_ph[j] = rise_pci ? 2 : 1;
        end else if (!differ) m_ph[j] = 0;
        else if (m_ph[j] == 1) begin
          if (rise_pci) m_ph[j] = 2;
        end else if (fall[src_of(j)]) begin
          m_gate[j] = req; m_ph[j] = 0;
        end
      end
    end
    for (int s = 0; s < 4; s++) m_prev[s] = sv[s];
    m_s2[0] = m_s1[0]; m_s2[1] = m_s1[1];
    m_s1[0] = dual_in[0]; m_s1[1] = dual_in[1];
  endtask

  function automatic logic [NT-1:0] outs();
    return {ref_o, dual_o, sd_o, pcif_o, pci_o, cpu_o};
  endfunction

  task automatic compare();
    logic [NT-1:0] act, exp, rexp;
    act = outs();
    for (int j = 0; j < NT; j++) begin
      exp[j] = m_out[j];
      rexp[j] = m_gate[j];
    end
    check({tag, " outputs"}, 32'(act), 32'(exp));
    check("R11 run state", 32'(run), 32'(rexp));
    for (int j = 0; j < NT; j++) begin
      if (act[j]) hl[j]++;
      else if (hl[j] > 0) begin
        check("R3 pulse width", hl[j], high_width(src_of(j)));
        hl[j] = 0;
      end
    end
  endtask

  task automatic cycle(input int n);
    for (int i = 0; i < n; i++) begin
      model_step();
      @(posedge clk); #1;
      compare();
      @(negedge clk);
      cyc++;
      drive_src();
    end
  endtask

  initial begin
    rst_n = 0; pwr_n = 1; mode = 1; dual_in = 2'b11;
    cpu_en = '1; pci_en = '1; pcif_en = 1; sd_en = '1; ref_en = '1;
    drive_src();
    repeat (3) @(negedge clk);
    #1;
    // R1: reset state
    check("R1 reset outputs", 32'(outs()), 0);
    check("R1 reset run", 32'(run), 0);
    check("R5 oe in clock mode", 32'(dual_oe), 32'h3);
    @(negedge clk);
    rst_n = 1; cyc = 0; drive_src(); model_reset();
    tag = "R2"; cycle(48);          // R2 start-up through handshake
    check("R2 all running", 32'(run), 32'h1FFFFF);
    tag = "R4"; cpu_en = 4'b0101; pci_en = 6'b110010; sd_en = 8'h5A; ref_en = 2'b10;
    cycle(48);
    tag = "R4"; cpu_en = '1; pci_en = '1; sd_en = '1; ref_en = '1; cycle(48);
    // R5: stop inputs in pin mode, ignored in clock mode
    tag = "R5"; mode = 0; cycle(24);
    check("R5 oe in pin mode", 32'(dual_oe), 0);
    check("R5 dual clocks stopped", 32'(run[18:17]), 0);
    tag = "R6"; dual_in[0] = 0; cycle(48);   // R12 latency covered by the model
    check("R6 cpu stopped", 32'(run[3:0]), 0);
    check("R6 sdram running", 32'(run[16:11]), 32'h3F);
    tag = "R7"; dual_in = 2'b01; cycle(48);
    check("R7 pci stopped", 32'(run[9:4]), 0);
    check("R7 free pci running", 32'(run[10]), 1);
    tag = "R12"; dual_in = 2'b11; cycle(48);
    tag = "R5"; mode = 1; dual_in = 2'b00; cycle(48);
    check("R5 stops ignored", 32'(run), 32'h1FFFFF);
    // R10: one-sample request with no PCI rise in that sample
    tag = "R10"; cpu_en[0] = 0; cycle(48 - (cyc % 8));
    cpu_en[0] = 1; cycle(1);
    cpu_en[0] = 0; cycle(16);
    check("R10 dropped request", 32'(run[0]), 0);
    cpu_en[0] = 1; cycle(24);
    // R8: asynchronous power-down
    tag = "R8"; pwr_n = 0; #1;
    check("R8 async outputs", 32'(outs()), 0);
    check("R8 async run", 32'(run), 0);
    model_clear();
    cycle(24);
    tag = "R9"; pwr_n = 1; cycle(2);
    check("R9 no instant restart", 32'(run), 0);
    cycle(46);
    check("R9 restarted", 32'(run), 32'h1FFFFF);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule